// File: doc/BRIEF.md
# Slot-Timed Instruction Sequencer for a Bus-Based Accumulator Machine

This block is the control unit of a small bus-based processor with a 16-bit data word, a 12-bit address and sixteen instructions. It steps through numbered time slots, eight per cycle, alternating between an instruction-fetch cycle and an execute cycle. In each slot it raises the strobes that pick which register drives the shared bus and which registers capture it. The registers are the program counter, the memory address register, the memory buffer, the X, Y and G registers and the keyboard input. The register file, the memory array, the ALU and the clock source sit outside the block.

Late in fetch, the word held in the memory buffer is split in one slot. Its low twelve bits go straight into the address register and its top four bits go into a 4-bit opcode register kept inside this block. That opcode register never reaches the bus. It feeds the decoder and the ALU operation select permanently, so the selected operation is steady for the whole execute cycle. The ALU result reaches the bus only through its send enable, and no result latch is used. Load-G, store-G and jump finish in fetch slots 6 and 7, request that execute be skipped, and the next cycle is a fresh fetch. A halt request, a halt instruction and a restart line control whether the slots advance.

All pins are plain strobes and levels. The slot timing is fixed, so there is no valid/ready stream and no back-pressure. The datapath must complete each strobed transfer inside its slot.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: After reset the sequencer is running, in fetch slot 0, and the opcode register holds 0.
- R2: Fetch slot 0 raises pc_send and mar_from_bus, slot 1 raises mem_read, and slot 2 raises pc_inc. Slots advance by one per clock while running.
- R3: Fetch slot 3 raises ir_load and mar_from_mbr, and the opcode register captures mbr_op at the end of that slot. Fetch slots 4 and 5 raise nothing.
- R4: During execute, alu_op equals the captured opcode and does not change.
- R5: At most one of pc_send, mbr_send, g_send, alu_send and kb_send is high in any cycle.
- R6: Load-G (opcode 12) raises mem_read in fetch slot 6 and raises mbr_send, g_load and skip_exec in fetch slot 7. The next cycle is fetch slot 0.
- R7: Jump (opcode 14) raises mem_read in fetch slot 6 and raises mbr_send, pc_load and skip_exec in fetch slot 7. The next cycle is fetch slot 0.
- R8: Store-G (opcode 13) raises g_send and mem_write in fetch slot 6 and raises only skip_exec in fetch slot 7. The next cycle is fetch slot 0.
- R9: Every other opcode enters an 8-slot execute cycle after fetch slot 7 and then returns to fetch slot 0. The ALU opcodes 3 to 10 raise alu_send and g_load in execute slot 0. Opcode 0 (no-op) raises nothing during execute.
- R10: Load-X (1) and load-Y (2) raise mem_read in execute slot 0, then mbr_send with x_load or y_load in execute slot 1. Keyboard-in (11) raises kb_send and g_load in execute slot 0.
- R11: The halt opcode (15) raises no strobe. It stops the sequencer at the end of execute slot 0, and running goes low.
- R12: halt_req high at a clock edge stops the sequencer and freezes the slot and phase. The strobes of that cycle are still issued. While stopped, every strobe is low.
- R13: While restart is high, the sequencer is stopped and parked at fetch slot 0. One clock after restart falls, it runs from fetch slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Park at fetch slot 0; run again after release |
| halt_req | input | 1 | Stop stepping at the next edge |
| mbr_op | input | 4 | Top four bits of the memory buffer |
| pc_send | output | 1 | Program counter drives the bus |
| mbr_send | output | 1 | Memory buffer drives the bus |
| g_send | output | 1 | G register drives the bus |
| alu_send | output | 1 | ALU result drives the bus |
| kb_send | output | 1 | Keyboard register drives the bus |
| pc_load | output | 1 | Program counter captures the bus |
| pc_inc | output | 1 | Program counter increments |
| mar_from_bus | output | 1 | Address register captures the bus |
| mar_from_mbr | output | 1 | Address register captures the low 12 buffer bits directly |
| ir_load | output | 1 | Opcode register captures mbr_op |
| mem_read | output | 1 | Memory read into the buffer |
| mem_write | output | 1 | Memory write from the bus |
| x_load | output | 1 | X captures the bus |
| y_load | output | 1 | Y captures the bus |
| g_load | output | 1 | G captures the bus |
| skip_exec | output | 1 | Next cycle is a fetch, not an execute |
| alu_op | output | 4 | ALU operation select (opcode register) |
| exec_phase | output | 1 | 1 in execute, 0 in fetch |
| slot | output | SLOT_W | Current slot number |
| running | output | 1 | Sequencer is stepping |

## Verification
The bench sends halt_req in the same cycle as the skip-execute decision of a jump, in fetch slot 7. The decoded jump strobes and the stop request then meet at one clock edge. The check passes when pc_load, mbr_send and skip_exec are all seen in that slot and the sequencer then sits stopped in fetch slot 7 with every strobe low. The check fails if the halt swallows the load or if the skip still moves the slot. A second collision puts restart over a running execute cycle: the park must win over the slot advance.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,
    OP_LDX = 4'd1,
    OP_LDY = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10,
    OP_KIN = 4'd11,
    OP_LDG = 4'd12,
    OP_STG = 4'd13,
    OP_JMP = 4'd14,
    OP_HLT = 4'd15
  } opcode_e;

  // bus drivers: at most one may be high
  typedef struct packed {
    logic pc_send;
    logic mbr_send;
    logic g_send;
    logic alu_send;
    logic kb_send;
  } send_t;

  typedef struct packed {
    logic pc_load;
    logic pc_inc;
    logic mar_from_bus;
    logic mar_from_mbr;
    logic ir_load;
    logic mem_read;
    logic mem_write;
    logic x_load;
    logic y_load;
    logic g_load;
    logic skip_exec;
    logic stop_req;
  } ctl_t;

  function automatic logic is_alu_op(opcode_e op);
    return (op >= OP_ADD) && (op <= OP_SHR);
  endfunction

  function automatic logic is_fetch_only(opcode_e op);
    return (op == OP_LDG) || (op == OP_STG) || (op == OP_JMP);
  endfunction

endpackage

// File: rtl/cpu_seq_slot_timer.sv
module cpu_seq_slot_timer #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              halt_req,
  input  logic              stop_op,
  input  logic              skip_exec,
  output logic [SLOT_W-1:0] slot,
  output logic              exec_phase,
  output logic              running
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic release_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot         <= '0;
      exec_phase   <= 1'b0;
      running      <= 1'b1;
      release_pend <= 1'b0;
    end else if (restart) begin
      slot         <= '0;
      exec_phase   <= 1'b0;
      running      <= 1'b0;
      release_pend <= 1'b1;
    end else if (release_pend) begin
      running      <= 1'b1;
      release_pend <= 1'b0;
    end else if (running) begin
      if (halt_req || stop_op) begin
        running <= 1'b0;
      end else if (slot == LAST) begin
        slot       <= '0;
        exec_phase <= !exec_phase && !skip_exec;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  AST_RESTART_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!running && slot == '0 && !exec_phase)); // R13

  AST_SLOT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart && !halt_req && !stop_op && slot != LAST)
      |=> (slot == $past(slot) + 1'b1)); // R2

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> ($stable(slot) && $stable(exec_phase))); // R12

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && halt_req && !restart) |=> !running); // R12

endmodule

// File: rtl/cpu_seq_opcode_reg.sv
module cpu_seq_opcode_reg
  import cpu_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] d,
  output logic [OP_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= OP_NOP;
    else if (load) q <= d;
  end

  AST_SPLIT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d))); // R3

endmodule

// File: rtl/cpu_seq_decode.sv
module cpu_seq_decode
  import cpu_seq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              exec_phase,
  input  logic [SLOT_W-1:0] slot,
  input  logic [OP_W-1:0]   ir,
  output send_t             snd,
  output ctl_t              ctl
);

  localparam logic [SLOT_W-1:0] S_ADDR  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] S_READ  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_INC   = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] S_SPLIT = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] S_LATE  = SLOT_W'(SLOTS - 2);
  localparam logic [SLOT_W-1:0] S_LAST  = SLOT_W'(SLOTS - 1);

  opcode_e op;
  assign op = opcode_e'(ir);

  always_comb begin
    snd = '0;
    ctl = '0;
    if (running) begin
      if (!exec_phase) begin
        if (slot == S_ADDR) begin
          snd.pc_send      = 1'b1;
          ctl.mar_from_bus = 1'b1;
        end else if (slot == S_READ) begin
          ctl.mem_read = 1'b1;
        end else if (slot == S_INC) begin
          ctl.pc_inc = 1'b1;
        end else if (slot == S_SPLIT) begin
          ctl.ir_load      = 1'b1;
          ctl.mar_from_mbr = 1'b1;
        end else if (slot == S_LATE) begin
          if (op == OP_LDG || op == OP_JMP) begin
            ctl.mem_read = 1'b1;
          end else if (op == OP_STG) begin
            snd.g_send    = 1'b1;
            ctl.mem_write = 1'b1;
          end
        end else if (slot == S_LAST) begin
          if (is_fetch_only(op)) ctl.skip_exec = 1'b1;
          if (op == OP_LDG) begin
            snd.mbr_send = 1'b1;
            ctl.g_load   = 1'b1;
          end else if (op == OP_JMP) begin
            snd.mbr_send = 1'b1;
            ctl.pc_load  = 1'b1;
          end
        end
      end else begin
        if (slot == S_ADDR) begin
          if (op == OP_LDX || op == OP_LDY) begin
            ctl.mem_read = 1'b1;
          end else if (is_alu_op(op)) begin
            snd.alu_send = 1'b1;
            ctl.g_load   = 1'b1;
          end else if (op == OP_KIN) begin
            snd.kb_send = 1'b1;
            ctl.g_load  = 1'b1;
          end else if (op == OP_HLT) begin
            ctl.stop_req = 1'b1;
          end
        end else if (slot == S_READ) begin
          if (op == OP_LDX) begin
            snd.mbr_send = 1'b1;
            ctl.x_load   = 1'b1;
          end else if (op == OP_LDY) begin
            snd.mbr_send = 1'b1;
            ctl.y_load   = 1'b1;
          end
        end
      end
    end
  end

  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snd)); // R5

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running) |-> ($countones({snd, ctl}) == 0)); // R12

endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
  import cpu_seq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              halt_req,
  input  logic [OP_W-1:0]   mbr_op,
  output logic              pc_send,
  output logic              mbr_send,
  output logic              g_send,
  output logic              alu_send,
  output logic              kb_send,
  output logic              pc_load,
  output logic              pc_inc,
  output logic              mar_from_bus,
  output logic              mar_from_mbr,
  output logic              ir_load,
  output logic              mem_read,
  output logic              mem_write,
  output logic              x_load,
  output logic              y_load,
  output logic              g_load,
  output logic              skip_exec,
  output logic [OP_W-1:0]   alu_op,
  output logic              exec_phase,
  output logic [SLOT_W-1:0] slot,
  output logic              running
);

  send_t           snd;
  ctl_t            ctl;
  logic [OP_W-1:0] ir_q;

  cpu_seq_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .halt_req   (halt_req),
    .stop_op    (ctl.stop_req),
    .skip_exec  (ctl.skip_exec),
    .slot       (slot),
    .exec_phase (exec_phase),
    .running    (running)
  );

  cpu_seq_opcode_reg u_ir (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctl.ir_load),
    .d     (mbr_op),
    .q     (ir_q)
  );

  cpu_seq_decode #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .exec_phase (exec_phase),
    .slot       (slot),
    .ir         (ir_q),
    .snd        (snd),
    .ctl        (ctl)
  );

  assign pc_send      = snd.pc_send;
  assign mbr_send     = snd.mbr_send;
  assign g_send       = snd.g_send;
  assign alu_send     = snd.alu_send;
  assign kb_send      = snd.kb_send;
  assign pc_load      = ctl.pc_load;
  assign pc_inc       = ctl.pc_inc;
  assign mar_from_bus = ctl.mar_from_bus;
  assign mar_from_mbr = ctl.mar_from_mbr;
  assign ir_load      = ctl.ir_load;
  assign mem_read     = ctl.mem_read;
  assign mem_write    = ctl.mem_write;
  assign x_load       = ctl.x_load;
  assign y_load       = ctl.y_load;
  assign g_load       = ctl.g_load;
  assign skip_exec    = ctl.skip_exec;
  assign alu_op       = ir_q;

  AST_OPCODE_HELD_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && $past(exec_phase)) |-> $stable(alu_op)); // R4

  AST_SKIP_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_exec && !halt_req && !restart)
      |=> (running && !exec_phase && slot == '0)); // R6

endmodule

// File: tb/cpu_seq_ctrl_tb.sv
module cpu_seq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 8;
  localparam int SW         = $clog2(SLOTS);

  // observation vector bit positions
  localparam int B_PCS = 15, B_MBS = 14, B_GS = 13, B_ALS = 12, B_KBS = 11;
  localparam int B_PCL = 10, B_PCI = 9, B_MARB = 8, B_MARM = 7, B_IRL = 6;
  localparam int B_RD = 5, B_WR = 4, B_XL = 3, B_YL = 2, B_GL = 1, B_SKIP = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic halt_req = 1'b0;
  logic [3:0] mbr_op = 4'd0;
  logic pc_send, mbr_send, g_send, alu_send, kb_send, pc_load, pc_inc;
  logic mar_from_bus, mar_from_mbr, ir_load, mem_read, mem_write;
  logic x_load, y_load, g_load, skip_exec, exec_phase, running;
  logic [3:0] alu_op;
  logic [SW-1:0] slot;

  int n_tests = 0;
  int n_fail  = 0;

  cpu_seq_ctrl #(.SLOTS(SLOTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .halt_req(halt_req),
    .mbr_op(mbr_op), .pc_send(pc_send), .mbr_send(mbr_send),
    .g_send(g_send), .alu_send(alu_send), .kb_send(kb_send),
    .pc_load(pc_load), .pc_inc(pc_inc), .mar_from_bus(mar_from_bus),
    .mar_from_mbr(mar_from_mbr), .ir_load(ir_load), .mem_read(mem_read),
    .mem_write(mem_write), .x_load(x_load), .y_load(y_load),
    .g_load(g_load), .skip_exec(skip_exec), .alu_op(alu_op),
    .exec_phase(exec_phase), .slot(slot), .running(running)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [15:0] obs();
    return {pc_send, mbr_send, g_send, alu_send, kb_send, pc_load, pc_inc,
            mar_from_bus, mar_from_mbr, ir_load, mem_read, mem_write,
            x_load, y_load, g_load, skip_exec};
  endfunction

  function automatic bit fetch_only(logic [3:0] op);
    return op == 4'd12 || op == 4'd13 || op == 4'd14;
  endfunction

  // expected strobes from the requirement text
  function automatic logic [15:0] exp_vec(bit ex, int s, logic [3:0] op);
    logic [15:0] v = '0;
    if (!ex) begin
      case (s)
        0: begin v[B_PCS] = 1; v[B_MARB] = 1; end          // R2
        1: v[B_RD] = 1;                                    // R2
        2: v[B_PCI] = 1;                                   // R2
        3: begin v[B_IRL] = 1; v[B_MARM] = 1; end          // R3
        6: begin
             if (op == 4'd12 || op == 4'd14) v[B_RD] = 1;  // R6 R7
             if (op == 4'd13) begin v[B_GS] = 1; v[B_WR] = 1; end // R8
           end
        7: begin
             if (fetch_only(op)) v[B_SKIP] = 1;
             if (op == 4'd12) begin v[B_MBS] = 1; v[B_GL] = 1; end
             if (op == 4'd14) begin v[B_MBS] = 1; v[B_PCL] = 1; end
           end
        default: ;
      endcase
    end else begin
      if (s == 0) begin
        if (op == 4'd1 || op == 4'd2) v[B_RD] = 1;                      // R10
        if (op >= 4'd3 && op <= 4'd10) begin v[B_ALS] = 1; v[B_GL] = 1; end // R9
        if (op == 4'd11) begin v[B_KBS] = 1; v[B_GL] = 1; end           // R10
      end else if (s == 1) begin
        if (op == 4'd1) begin v[B_MBS] = 1; v[B_XL] = 1; end
        if (op == 4'd2) begin v[B_MBS] = 1; v[B_YL] = 1; end
      end
    end
    return v;
  endfunction

  function automatic string tag(bit ex, int s, logic [3:0] op);
    if (!ex) begin
      if (s < 3) return "R2";
      if (s < 6) return "R3";
      if (op == 4'd12) return "R6";
      if (op == 4'd14) return "R7";
      if (op == 4'd13) return "R8";
      return "R9";
    end
    if (op == 4'd1 || op == 4'd2 || op == 4'd11) return "R10";
    return "R9";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step_check(bit ex, int s, logic [3:0] op);
    string t = tag(ex, s, op);
    chk(t, "strobes", 32'(obs()), 32'(exp_vec(ex, s, op)));
    chk(t, "phase", 32'(exec_phase), 32'(ex));
    chk(t, "slot", 32'(slot), 32'(s));
    chk(t, "running", 32'(running), 32'd1);
    chk("R5", "bus drivers", 32'($countones(obs() & 16'hF800) <= 1), 32'd1);
    if (ex) chk("R4", "alu_op", 32'(alu_op), 32'(op));
    @(negedge clk);
  endtask

  task automatic run_instr(logic [3:0] op);
    mbr_op = op;
    for (int s = 0; s < SLOTS; s++) step_check(1'b0, s, op);
    if (!fetch_only(op))
      for (int s = 0; s < SLOTS; s++) step_check(1'b1, s, op);
    chk(fetch_only(op) ? tag(1'b0, 7, op) : "R9", "back to fetch",
        {31'd0, exec_phase} | 32'(slot), 32'd0);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    chk("R13", "parked running", 32'(running), 32'd0);
    chk("R13", "parked slot", 32'(slot), 32'd0);
    chk("R13", "parked phase", 32'(exec_phase), 32'd0);
    chk("R13", "parked strobes", 32'(obs()), 32'd0);
    restart = 1'b0;
    @(negedge clk);
    chk("R13", "resumed running", 32'(running), 32'd1);
    chk("R13", "resumed slot", 32'(slot), 32'd0);
    chk("R13", "resumed phase", 32'(exec_phase), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "running", 32'(running), 32'd1);
    chk("R1", "slot", 32'(slot), 32'd0);
    chk("R1", "phase", 32'(exec_phase), 32'd0);
    chk("R1", "opcode reg", 32'(alu_op), 32'd0);
  endtask

  task automatic t_halt_op();
    mbr_op = 4'd15;
    for (int s = 0; s < SLOTS; s++) step_check(1'b0, s, 4'd15);
    chk("R11", "exec slot0 strobes", 32'(obs()), 32'd0);
    chk("R11", "in execute", 32'(exec_phase), 32'd1);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R11", "stopped", 32'(running), 32'd0);
      chk("R11", "frozen slot", 32'(slot), 32'd0);
      chk("R12", "stopped strobes", 32'(obs()), 32'd0);
      @(negedge clk);
    end
    do_restart();
  endtask

  task automatic t_halt_mid();
    mbr_op = 4'd3;
    step_check(1'b0, 0, 4'd3);
    step_check(1'b0, 1, 4'd3);
    halt_req = 1'b1;
    chk("R12", "strobes in halt cycle", 32'(obs()), 32'(exp_vec(1'b0, 2, 4'd3)));
    @(negedge clk);
    halt_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R12", "stopped", 32'(running), 32'd0);
      chk("R12", "frozen slot", 32'(slot), 32'd2);
      chk("R12", "stopped strobes", 32'(obs()), 32'd0);
      @(negedge clk);
    end
    do_restart();
  endtask

  task automatic t_halt_skip_collide();
    mbr_op = 4'd14;
    for (int s = 0; s < 7; s++) step_check(1'b0, s, 4'd14);
    halt_req = 1'b1;
    chk("R7", "jump strobes with halt", 32'(obs()), 32'(exp_vec(1'b0, 7, 4'd14)));
    @(negedge clk);
    halt_req = 1'b0;
    chk("R12", "stopped after collide", 32'(running), 32'd0);
    chk("R12", "slot held at 7", 32'(slot), 32'd7);
    chk("R12", "phase held", 32'(exec_phase), 32'd0);
    chk("R12", "strobes low", 32'(obs()), 32'd0);
    @(negedge clk);
    chk("R12", "still frozen", 32'(slot), 32'd7);
    do_restart();
  endtask

  task automatic t_restart_exec();
    mbr_op = 4'd4;
    for (int s = 0; s < SLOTS; s++) step_check(1'b0, s, 4'd4);
    for (int s = 0; s < 3; s++) step_check(1'b1, s, 4'd4);
    do_restart();
    run_instr(4'd7);
  endtask

  initial begin
    t_reset();
    run_instr(4'd3);   // R9 ALU add
    run_instr(4'd8);   // R9 ALU not
    run_instr(4'd1);   // R10 load X
    run_instr(4'd2);   // R10 load Y
    run_instr(4'd11);  // R10 keyboard in
    run_instr(4'd0);   // R9 no-op
    run_instr(4'd12);  // R6 load G
    run_instr(4'd13);  // R8 store G
    run_instr(4'd14);  // R7 jump
    run_instr(4'd10);  // R9 ALU op after fetch-only run
    t_halt_op();       // R11
    t_halt_mid();      // R12
    t_halt_skip_collide(); // R7 R12
    t_restart_exec();  // R13
    run_instr(4'd12);  // R6
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule